// File: doc/BRIEF.md
# Fine-Grained Multithreaded Warp Issue Scheduler

This block is the issue scheduler of a small SIMD multiprocessor. It holds a table of hardware thread-group contexts (warps). Each context has an enable bit, a stall bit and its own program counter. A warp is 32 threads that run the same instruction together. The datapath has only 8 lanes, so one warp instruction goes out over 4 back-to-back cycles, one lane group of 8 threads per cycle.

At every issue-group boundary the scheduler picks a new warp. The search is round-robin and starts at the warp after the one that issued last. Only enabled warps that are not stalled can be picked, so warps are interleaved one instruction at a time and stalled warps are skipped. The picked warp's PC is presented for all four cycles of its group. The PC advances by one when the group finishes. Stall-set and stall-clear events come from the rest of the core, as do enable commands (which load a start PC) and retire commands. Fetch, decode, register files and execution units sit outside this block.

Top module: `wsched_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `issueValid` is 0, `idle` is 1 and `laneGroup` is 0. No warp is enabled after reset.
- R2: An issue group lasts exactly 4 cycles. During it, `laneGroup` counts 0, 1, 2, 3, where lane group k covers threads 8k to 8k+7. `issueWarp` stays constant for the whole group.
- R3: At each selection the scheduler searches the warps in ascending index order, wrapping from the last warp to warp 0. The search begins at the warp after the most recently issued one. Before any warp has issued, the search begins at warp 0.
- R4: Only warps that are enabled and not stalled can be selected. A stalled warp is passed over while other eligible warps keep issuing.
- R5: A stall raised for the warp that is currently issuing does not shorten its group. It takes effect at the next selection.
- R6: A `stallClear` bit makes that warp eligible again. If `stallSet` and `stallClear` are both high for the same warp in the same cycle, the warp ends up stalled.
- R7: Selection happens at a group boundary. If no warp is eligible there, `issueValid` is 0, `idle` is 1 and `laneGroup` is 0 in the next cycle, and selection is tried again on every following cycle. A command presented at a clock edge affects the selection made at the next edge.
- R8: When a group completes, the PC of the issuing warp increments by 1, modulo 2^16. An enable command loads the warp's PC from `startPc` and clears its stall bit. An enable command for a warp takes priority over that warp's increment.
- R9: A retire command clears the warp's enable bit. A retire command beats an enable command for the same warp in the same cycle. A group already in flight for a retired warp still completes all 4 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stallSet | input | 24 | One bit per warp: mark the warp stalled |
| stallClear | input | 24 | One bit per warp: clear the warp's stall |
| enableReq | input | 24 | One bit per warp: enable the warp and load its PC from startPc |
| retireReq | input | 24 | One bit per warp: disable the warp |
| startPc | input | 16 | PC loaded by an enable command |
| issueValid | output | 1 | A warp instruction is being issued this cycle |
| idle | output | 1 | No warp is issuing this cycle |
| issueWarp | output | 5 | Index of the issuing warp |
| issuePc | output | 16 | PC of the issuing warp |
| laneGroup | output | 2 | Lane group of the current cycle (0..3) |

## Verification
The hardest case to reach is a stall or retire that lands in the middle of a group for the warp that is issuing. The bench has to know which warp is in flight and which lane group it is on before it drives the event. To get there, the bench steps cycle by cycle and watches the outputs. It waits until the target warp shows lane group 0 and then raises the stall on the very next cycle. It then confirms that the group still runs to lane group 3 and that the warp is left out of later selections. A long pseudo-random sweep then mixes enables, retires, stalls and simultaneous set/clear events on all 24 warps. Every cycle is compared against an arithmetic model, which covers wrap-around of the round-robin search and idle gaps.

// File: rtl/wsched_pkg.sv
`timescale 1ns/1ps
package wsched_pkg;

  // Strobes from control to the context datapath
  typedef struct packed {
    logic selectNew;  // a new warp was picked at this edge
    logic groupDone;  // the in-flight group ends at this edge
  } schedStrobe_t;

endpackage

// File: rtl/wsched_rr_pick.sv
`timescale 1ns/1ps
module wsched_rr_pick #(
  parameter int NUM_WARPS = 24,
  parameter int IDW       = 5
) (
  input  logic [NUM_WARPS-1:0] eligible,
  input  logic [IDW-1:0]       lastId,
  output logic                 found,
  output logic [IDW-1:0]       pickId
);

  // Walk offsets from far to near so the nearest eligible warp wins.
  always_comb begin
    found  = 1'b0;
    pickId = '0;
    for (int ofs = NUM_WARPS; ofs >= 1; ofs--) begin
      int idx;
      idx = (int'(lastId) + ofs) % NUM_WARPS;
      if (eligible[IDW'(idx)]) begin
        found  = 1'b1;
        pickId = IDW'(idx);
      end
    end
  end

endmodule

// File: rtl/wsched_ctrl.sv
`timescale 1ns/1ps
module wsched_ctrl
  import wsched_pkg::*;
#(
  parameter int NUM_WARPS    = 24,
  parameter int IDW          = 5,
  parameter int GROUP_CYCLES = 4,
  parameter int LGW          = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_WARPS-1:0] eligible,
  output schedStrobe_t         strobe,
  output logic                 active,
  output logic [IDW-1:0]       curWarp,
  output logic [LGW-1:0]       laneCnt
);

  localparam logic [LGW-1:0] LAST_LANE = LGW'(GROUP_CYCLES - 1);
  localparam logic [IDW-1:0] INIT_LAST = IDW'(NUM_WARPS - 1);

  logic           boundary;
  logic           found;
  logic [IDW-1:0] pickId;
  logic [IDW-1:0] lastWarp;

  wsched_rr_pick #(.NUM_WARPS(NUM_WARPS), .IDW(IDW)) u_pick (
    .eligible(eligible),
    .lastId  (lastWarp),
    .found   (found),
    .pickId  (pickId)
  );

  assign boundary         = !active || (laneCnt == LAST_LANE);
  assign strobe.groupDone = active && (laneCnt == LAST_LANE);
  assign strobe.selectNew = boundary && found;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      curWarp  <= '0;
      laneCnt  <= '0;
      lastWarp <= INIT_LAST;
    end else if (boundary) begin
      laneCnt <= '0;
      active  <= found;
      if (found) begin
        curWarp  <= pickId;
        lastWarp <= pickId;
      end
    end else begin
      laneCnt <= laneCnt + LGW'(1);
    end
  end

endmodule

// File: rtl/wsched_datapath.sv
`timescale 1ns/1ps
module wsched_datapath
  import wsched_pkg::*;
#(
  parameter int NUM_WARPS = 24,
  parameter int IDW       = 5,
  parameter int PCW       = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_WARPS-1:0]          stallSet,
  input  logic [NUM_WARPS-1:0]          stallClear,
  input  logic [NUM_WARPS-1:0]          enableReq,
  input  logic [NUM_WARPS-1:0]          retireReq,
  input  logic [PCW-1:0]                startPc,
  input  schedStrobe_t                  strobe,
  input  logic [IDW-1:0]                curWarp,
  output logic [NUM_WARPS-1:0]          warpEn,
  output logic [NUM_WARPS-1:0]          warpEligible,
  output logic [NUM_WARPS-1:0][PCW-1:0] warpPc
);

  logic [NUM_WARPS-1:0] warpStall;

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_ctx
    logic loadCtx;
    logic bumpPc;

    assign loadCtx = enableReq[w] && !retireReq[w];
    assign bumpPc  = strobe.groupDone && (curWarp == IDW'(w));
    assign warpEligible[w] = warpEn[w] && !warpStall[w];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        warpEn[w]    <= 1'b0;
        warpStall[w] <= 1'b0;
        warpPc[w]    <= '0;
      end else begin
        if (retireReq[w])      warpEn[w] <= 1'b0;
        else if (enableReq[w]) warpEn[w] <= 1'b1;

        if (stallSet[w])                   warpStall[w] <= 1'b1;
        else if (stallClear[w] || loadCtx) warpStall[w] <= 1'b0;

        if (loadCtx)     warpPc[w] <= startPc;
        else if (bumpPc) warpPc[w] <= warpPc[w] + PCW'(1);
      end
    end
  end

endmodule

// File: rtl/wsched_top.sv
`timescale 1ns/1ps
module wsched_top
  import wsched_pkg::*;
#(
  parameter int NUM_WARPS    = 24,
  parameter int WARP_THREADS = 32,
  parameter int LANES        = 8,
  parameter int PCW          = 16,
  localparam int GROUP_CYCLES = WARP_THREADS / LANES,
  localparam int IDW          = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
  localparam int LGW          = (GROUP_CYCLES > 1) ? $clog2(GROUP_CYCLES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_WARPS-1:0] stallSet,
  input  logic [NUM_WARPS-1:0] stallClear,
  input  logic [NUM_WARPS-1:0] enableReq,
  input  logic [NUM_WARPS-1:0] retireReq,
  input  logic [PCW-1:0]       startPc,
  output logic                 issueValid,
  output logic                 idle,
  output logic [IDW-1:0]       issueWarp,
  output logic [PCW-1:0]       issuePc,
  output logic [LGW-1:0]       laneGroup
);

  schedStrobe_t                  strobe;
  logic                          active;
  logic [IDW-1:0]                curWarp;
  logic [LGW-1:0]                laneCnt;
  logic [NUM_WARPS-1:0]          warpEn;
  logic [NUM_WARPS-1:0]          warpEligible;
  logic [NUM_WARPS-1:0][PCW-1:0] warpPc;

  wsched_ctrl #(
    .NUM_WARPS(NUM_WARPS), .IDW(IDW), .GROUP_CYCLES(GROUP_CYCLES), .LGW(LGW)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .eligible(warpEligible),
    .strobe  (strobe),
    .active  (active),
    .curWarp (curWarp),
    .laneCnt (laneCnt)
  );

  wsched_datapath #(.NUM_WARPS(NUM_WARPS), .IDW(IDW), .PCW(PCW)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .stallSet    (stallSet),
    .stallClear  (stallClear),
    .enableReq   (enableReq),
    .retireReq   (retireReq),
    .startPc     (startPc),
    .strobe      (strobe),
    .curWarp     (curWarp),
    .warpEn      (warpEn),
    .warpEligible(warpEligible),
    .warpPc      (warpPc)
  );

  assign issueValid = active;
  assign idle       = !active;
  assign issueWarp  = curWarp;
  assign issuePc    = warpPc[curWarp];
  assign laneGroup  = laneCnt;

endmodule

// File: rtl/wsched_checker.sv
`timescale 1ns/1ps
module wsched_checker #(
  parameter int NUM_WARPS = 24,
  parameter int IDW       = 5,
  parameter int PCW       = 16,
  parameter int LGW       = 2
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          issueValid,
  input logic [IDW-1:0]                issueWarp,
  input logic [PCW-1:0]                issuePc,
  input logic [LGW-1:0]                laneGroup,
  input logic [NUM_WARPS-1:0]          enableReq,
  input logic [NUM_WARPS-1:0]          retireReq,
  input logic [NUM_WARPS-1:0]          warpEn,
  input logic [NUM_WARPS-1:0]          warpEligible,
  input logic [NUM_WARPS-1:0][PCW-1:0] warpPc
);

  localparam logic [LGW-1:0] LAST_LANE = '1;

  logic [NUM_WARPS-1:0] prevElig;
  always_ff @(posedge clk) prevElig <= warpEligible;

  // R2: a group steps through its lane groups without changing warp
  assert_lane_sequence_R2: assert property (@(posedge clk) disable iff (!rst_n)
    issueValid && laneGroup != LAST_LANE |=>
      issueValid && laneGroup == LGW'($past(laneGroup) + 1'b1) &&
      issueWarp == $past(issueWarp));

  // R4: a newly started group belongs to a warp that was eligible
  assert_pick_eligible_R4: assert property (@(posedge clk) disable iff (!rst_n)
    issueValid && laneGroup == '0 |-> prevElig[issueWarp]);

  // R7: no eligible warp at a boundary leaves the next slot empty
  assert_idle_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (warpEligible == '0) && (!issueValid || laneGroup == LAST_LANE) |=> !issueValid);

  // R8: completing a group advances that warp's PC by one
  assert_pc_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    issueValid && laneGroup == LAST_LANE && !enableReq[issueWarp] |=>
      warpPc[$past(issueWarp)] == $past(issuePc) + PCW'(1));

  // R9: a retired warp is disabled after the edge
  assert_retire_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (retireReq != '0) |=> (warpEn & $past(retireReq)) == '0);

endmodule

bind wsched_top wsched_checker #(
  .NUM_WARPS(NUM_WARPS), .IDW(IDW), .PCW(PCW), .LGW(LGW)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .issueValid  (issueValid),
  .issueWarp   (issueWarp),
  .issuePc     (issuePc),
  .laneGroup   (laneGroup),
  .enableReq   (enableReq),
  .retireReq   (retireReq),
  .warpEn      (warpEn),
  .warpEligible(warpEligible),
  .warpPc      (warpPc)
);

// File: tb/wsched_top_tb.sv
`timescale 1ns/1ps
module wsched_top_tb;

  localparam int NW = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NW-1:0] stallSet = '0, stallClear = '0, enableReq = '0, retireReq = '0;
  logic [15:0]   startPc = '0;
  logic          issueValid, idle;
  logic [4:0]    issueWarp;
  logic [15:0]   issuePc;
  logic [1:0]    laneGroup;

  always #4 clk = ~clk;  // 125 MHz

  wsched_top u_dut (
    .clk(clk), .rst_n(rst_n), .stallSet(stallSet), .stallClear(stallClear),
    .enableReq(enableReq), .retireReq(retireReq), .startPc(startPc),
    .issueValid(issueValid), .idle(idle), .issueWarp(issueWarp),
    .issuePc(issuePc), .laneGroup(laneGroup)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // Reference model state
  bit       mEn[NW], mStall[NW];
  bit [15:0] mPc[NW];
  bit       mActive = 0;
  int       mCur = 0, mLane = 0, mLast = NW - 1;

  int logW[0:8191];
  int logN = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareOutputs();
    chk(issueValid == mActive, "R7 issueValid", issueValid, mActive);
    chk(idle == !mActive, "R7 idle", idle, !mActive);
    chk(int'(laneGroup) == mLane, "R2 laneGroup", laneGroup, mLane);
    if (mActive) begin
      chk(int'(issueWarp) == mCur, "R3 issueWarp", issueWarp, mCur);
      chk(issuePc == mPc[mCur], "R8 issuePc", issuePc, mPc[mCur]);
    end
    if (issueValid && laneGroup == 2'd0 && logN < 8192) begin
      logW[logN] = int'(issueWarp);
      logN++;
    end
  endtask

  task automatic tick(input logic [NW-1:0] sS, input logic [NW-1:0] sC,
                      input logic [NW-1:0] eR, input logic [NW-1:0] rR,
                      input logic [15:0] sp);
    int incW;
    bit found;
    @(negedge clk);
    compareOutputs();
    stallSet = sS; stallClear = sC; enableReq = eR; retireReq = rR; startPc = sp;
    incW = (mActive && mLane == 3) ? mCur : -1;
    if (!mActive || mLane == 3) begin
      found = 0;
      for (int k = 1; k <= NW; k++) begin
        int w;
        w = (mLast + k) % NW;
        if (!found && mEn[w] && !mStall[w]) begin
          found = 1; mCur = w; mLast = w;
        end
      end
      mActive = found;
      mLane = 0;
    end else begin
      mLane++;
    end
    for (int w = 0; w < NW; w++) begin
      bit ld;
      ld = eR[w] && !rR[w];
      if (rR[w]) mEn[w] = 0; else if (eR[w]) mEn[w] = 1;
      if (sS[w]) mStall[w] = 1; else if (sC[w] || ld) mStall[w] = 0;
      if (ld) mPc[w] = sp; else if (w == incW) mPc[w] = mPc[w] + 16'd1;
    end
  endtask

  task automatic quiet(input int n);
    for (int i = 0; i < n; i++) tick('0, '0, '0, '0, 16'd0);
  endtask

  function automatic logic [NW-1:0] bitOf(input int w);
    logic [NW-1:0] v;
    v = '0;
    v[w] = 1'b1;
    return v;
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int mark;
    bit seen;
    logic [31:0] lfsr;
    for (int w = 0; w < NW; w++) begin mEn[w] = 0; mStall[w] = 0; mPc[w] = 0; end

    // R1: reset state
    repeat (3) begin
      @(negedge clk);
      chk(issueValid == 0 && idle == 1 && laneGroup == 0, "R1 reset outputs",
          {issueValid, idle, laneGroup}, 4'b0100);
    end
    rst_n = 1'b1;
    quiet(3);  // R1: stays idle with nothing enabled

    // R3: enable warps 3, 7 and 20 together; order must be 3, 7, 20, 3
    mark = logN;
    tick('0, '0, bitOf(3) | bitOf(7) | bitOf(20), '0, 16'd100);
    quiet(20);
    chk(logW[mark] == 3,   "R3 first pick",  logW[mark], 3);
    chk(logW[mark+1] == 7, "R3 second pick", logW[mark+1], 7);
    chk(logW[mark+2] == 20,"R3 third pick",  logW[mark+2], 20);
    chk(logW[mark+3] == 3, "R3 wrap pick",   logW[mark+3], 3);

    // R5: stall warp 7 while it is at lane group 1
    for (int i = 0; i < 40; i++) begin
      tick('0, '0, '0, '0, 16'd0);
      if (issueValid && issueWarp == 5'd7 && laneGroup == 2'd0) break;
    end
    tick(bitOf(7), '0, '0, '0, 16'd0);
    tick('0, '0, '0, '0, 16'd0);
    chk(issueValid && issueWarp == 5'd7 && laneGroup == 2'd2, "R5 group continues",
        {issueWarp, laneGroup}, {5'd7, 2'd2});
    tick('0, '0, '0, '0, 16'd0);
    chk(issueValid && issueWarp == 5'd7 && laneGroup == 2'd3, "R5 group completes",
        {issueWarp, laneGroup}, {5'd7, 2'd3});
    mark = logN;
    quiet(28);
    seen = 0;
    for (int i = mark; i < logN; i++) if (logW[i] == 7) seen = 1;
    chk(!seen, "R4 stalled warp skipped", seen, 0);

    // R6: set and clear together on warp 3 leaves it stalled
    tick(bitOf(3), bitOf(3), '0, '0, 16'd0);
    quiet(4);
    mark = logN;
    quiet(24);
    seen = 0;
    for (int i = mark; i < logN; i++) if (logW[i] != 20) seen = 1;
    chk(!seen, "R6 set wins over clear", seen, 0);
    tick('0, bitOf(3) | bitOf(7), '0, '0, 16'd0);
    mark = logN;
    quiet(28);
    seen = 0;
    for (int i = mark; i < logN; i++) if (logW[i] == 7) seen = 1;
    chk(seen, "R6 clear restores eligibility", seen, 1);

    // R7: retire everything -> idle slots
    tick('0, '0, '0, '1, 16'd0);
    quiet(6);
    chk(!issueValid && idle && laneGroup == 0, "R7 idle after retire",
        {issueValid, idle, laneGroup}, 4'b0100);

    // R9: enable and retire of the same warp in one cycle -> stays disabled
    tick('0, '0, bitOf(0), bitOf(0), 16'd5);
    quiet(4);
    chk(!issueValid, "R9 retire beats enable", issueValid, 0);

    // R8: single warp back-to-back with PC wrap
    tick('0, '0, bitOf(5), '0, 16'hFFFE);
    tick('0, '0, '0, '0, 16'd0);  // selection edge
    tick('0, '0, '0, '0, 16'd0);
    chk(issuePc == 16'hFFFE, "R8 start PC", issuePc, 16'hFFFE);
    quiet(4);
    chk(issuePc == 16'hFFFF, "R8 increment", issuePc, 16'hFFFF);
    quiet(4);
    chk(issuePc == 16'h0000, "R8 wrap", issuePc, 0);

    // R9: retire warp 5 at lane group 1; group still completes
    for (int i = 0; i < 8; i++) begin
      tick('0, '0, '0, '0, 16'd0);
      if (laneGroup == 2'd0) break;
    end
    tick('0, '0, '0, bitOf(5), 16'd0);
    tick('0, '0, '0, '0, 16'd0);
    chk(issueValid && laneGroup == 2'd2, "R9 in-flight group continues", laneGroup, 2);
    quiet(3);
    chk(!issueValid, "R9 retired warp no longer issues", issueValid, 0);

    // Sweep: pseudo-random events on all warps, every cycle compared
    lfsr = 32'h1ACE_B00C;
    for (int i = 0; i < 6000; i++) begin
      logic [NW-1:0] sS, sC, eR, rR;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      sS = (lfsr[2:0] == 0) ? bitOf(int'(lfsr[12:8]) % NW) : '0;
      sC = (lfsr[4:3] == 0) ? bitOf(int'(lfsr[17:13]) % NW) : '0;
      eR = (lfsr[7:5] == 0) ? bitOf(int'(lfsr[22:18]) % NW) : '0;
      rR = (lfsr[27:24] == 0) ? bitOf(int'(lfsr[12:8]) % NW) : '0;
      if (lfsr[31:28] == 0) sC = sC | sS;  // simultaneous set/clear, R6
      tick(sS, sC, eR, rR, lfsr[15:0]);
    end
    quiet(4);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule